// File: doc/BRIEF.md
# Cache Diagnostic Word Access Port

This block gives software a two-register window into an instruction cache data array, one 64-bit word at a time. The index register holds three fields: a way number, a line number and a word selector. The data register reads or writes the array word that those fields point at. Both registers sit on a small register bus with a one-bit select, read and write strobes, and 64-bit write and read data.

Each access to the data register steps the word selector, so four back-to-back data accesses walk through a whole line. Two side-effect strobes come from the neighbouring tag registers. Either strobe clears the word selector. Only the auto-increment strobe also advances the combined way/line counter. With these strobes, software can sweep the whole array with no index rewrites.

The data array is a behavioural model inside the block, sized by parameters. Only the low bits of the way and line fields address it, so larger index values alias onto the stored words.

Top module: `icache_diag_port`

## Requirements
- R1: After synchronous reset, the index register reads as zero in every field.
- R2: Reading the index register (select 0) returns line in bits 6:0, way in bits 10:7 and word select in bits 17:16. Bits 15:11 and 63:18 are read-only and always read as zero, even after a write of all ones.
- R3: A write to the index register loads line, way and word select from the same bit positions. This load takes priority over any tag strobe that arrives in the same cycle.
- R4: Each data-register access (select 1, read or write) increments the word select at the following clock edge, and the value wraps from 3 to 0.
- R5: A plain tag strobe or an auto-increment tag strobe clears the word select to 0. In the same cycle this clear overrides the data-access increment.
- R6: An auto-increment tag strobe advances the 11-bit counter {way, line} by one, with a carry from line into way, and wraps from 2047 to 0.
- R7: A plain tag strobe leaves way and line unchanged.
- R8: A data-register read returns, in the same cycle, the 64-bit array word at {way low bits, line low bits, word select}. A data-register write stores the full 64-bit word at that location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 index, 1 data |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data (zero when reg_rd is low) |
| tag_plain_acc | input | 1 | Side-effect strobe from a plain tag register access |
| tag_incr_acc | input | 1 | Side-effect strobe from an auto-increment tag register access |

## Verification
The bench writes a run of lines that starts near the top of a way, so the line field carries into the way field and the aliased array locations are overwritten. It then reads every word back against a scoreboard. A design whose carry is broken or whose word selector fails to wrap would return the wrong words. The bench also fires tag strobes in the same cycle as a data access and in the same cycle as an index write. A design with the priority reversed would leave a stale word selector or lose the written fields. It forces the counter wrap from all ones to zero, and it writes all ones to the index register to prove that no reserved bit can be set.

// File: rtl/icdiag_pkg.sv
package icdiag_pkg;

    localparam int REG_W   = 64;
    localparam int LINE_W  = 7;
    localparam int WAY_W   = 4;
    localparam int DSEL_W  = 2;
    localparam int CNT_W   = WAY_W + LINE_W;
    localparam int LINE_LSB = 0;
    localparam int WAY_LSB  = 7;
    localparam int DSEL_LSB = 16;

    typedef enum logic {
        SEL_INDEX = 1'b0,
        SEL_DATA  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [WAY_W-1:0]  way;
        logic [LINE_W-1:0] line;
        logic [DSEL_W-1:0] dsel;
    } idx_t;

    function automatic logic [REG_W-1:0] pack_index(input idx_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[LINE_LSB +: LINE_W] = f.line;
        w[WAY_LSB  +: WAY_W]  = f.way;
        w[DSEL_LSB +: DSEL_W] = f.dsel;
        return w;
    endfunction

    function automatic idx_t unpack_index(input logic [REG_W-1:0] w);
        idx_t f;
        f.line = w[LINE_LSB +: LINE_W];
        f.way  = w[WAY_LSB  +: WAY_W];
        f.dsel = w[DSEL_LSB +: DSEL_W];
        return f;
    endfunction

endpackage

// File: rtl/icdiag_index_ctrl.sv
module icdiag_index_ctrl
    import icdiag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idx_wr,
    input  idx_t idx_wdata,
    input  logic tag_plain,
    input  logic tag_incr,
    input  logic data_acc,
    output idx_t idx_q
);

    logic [CNT_W-1:0] cnt_cur;
    logic [CNT_W-1:0] cnt_nxt;
    logic             tag_any;

    assign cnt_cur = {idx_q.way, idx_q.line};
    assign cnt_nxt = cnt_cur + 1'b1;
    assign tag_any = tag_plain | tag_incr;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= idx_wdata;
        end else begin
            if (tag_incr) begin
                {idx_q.way, idx_q.line} <= cnt_nxt;
            end
            if (tag_any) begin
                idx_q.dsel <= '0;
            end else if (data_acc) begin
                idx_q.dsel <= idx_q.dsel + 1'b1;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (idx_q == '0)); // R1

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> (idx_q == $past(idx_wdata))); // R3

    AST_DSEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !idx_wr && !tag_plain && !tag_incr)
        |=> (idx_q.dsel == DSEL_W'($past(idx_q.dsel) + 1'b1))); // R4

    AST_TAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((tag_plain || tag_incr) && !idx_wr) |=> (idx_q.dsel == '0)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tag_incr && !idx_wr)
        |=> ({idx_q.way, idx_q.line} == CNT_W'({$past(idx_q.way), $past(idx_q.line)} + 1'b1))); // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tag_incr && !idx_wr) |=> ($stable(idx_q.way) && $stable(idx_q.line))); // R7

endmodule

// File: rtl/icdiag_data_array.sv
module icdiag_data_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/icdiag_rd_mux.sv
module icdiag_rd_mux
    import icdiag_pkg::*;
(
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] idx_word,
    input  logic [REG_W-1:0] arr_word,
    output logic [REG_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_INDEX: rdata = idx_word;
                SEL_DATA:  rdata = arr_word;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/icache_diag_port.sv
module icache_diag_port
    import icdiag_pkg::*;
#(
    parameter int WAY_AW  = 2,
    parameter int LINE_AW = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_sel,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    input  logic        tag_plain_acc,
    input  logic        tag_incr_acc
);

    localparam int ARR_AW = WAY_AW + LINE_AW + DSEL_W;

    reg_sel_e           sel;
    logic               idx_wr;
    logic               data_acc;
    logic               data_wr;
    idx_t               idx_q;
    logic [ARR_AW-1:0]  arr_addr;
    logic [REG_W-1:0]   arr_rdata;
    logic [REG_W-1:0]   idx_word;

    assign sel      = reg_sel_e'(reg_sel);
    assign idx_wr   = reg_wr && (sel == SEL_INDEX);
    assign data_acc = (reg_rd || reg_wr) && (sel == SEL_DATA);
    assign data_wr  = reg_wr && (sel == SEL_DATA);
    assign idx_word = pack_index(idx_q);

    generate
        if (WAY_AW == 0) begin : g_direct_map
            assign arr_addr = {idx_q.line[LINE_AW-1:0], idx_q.dsel};
        end else begin : g_way_map
            assign arr_addr = {idx_q.way[WAY_AW-1:0], idx_q.line[LINE_AW-1:0], idx_q.dsel};
        end
    endgenerate

    icdiag_index_ctrl u_index (
        .clk       (clk),
        .rst       (rst),
        .idx_wr    (idx_wr),
        .idx_wdata (unpack_index(reg_wdata)),
        .tag_plain (tag_plain_acc),
        .tag_incr  (tag_incr_acc),
        .data_acc  (data_acc),
        .idx_q     (idx_q)
    );

    icdiag_data_array #(
        .ADDR_W (ARR_AW),
        .DATA_W (REG_W)
    ) u_array (
        .clk   (clk),
        .we    (data_wr),
        .addr  (arr_addr),
        .wdata (reg_wdata),
        .rdata (arr_rdata)
    );

    icdiag_rd_mux u_rdmux (
        .rd_en    (reg_rd),
        .sel      (sel),
        .idx_word (idx_word),
        .arr_word (arr_rdata),
        .rdata    (reg_rdata)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_sel) |-> ((reg_rdata[63:18] == '0) && (reg_rdata[15:11] == '0))); // R2

endmodule

// File: tb/icache_diag_port_tb.sv
`timescale 1ns/1ps
module icache_diag_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        tag_plain_acc = 1'b0;
    logic        tag_incr_acc = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    int m_cnt  = 0;
    int m_dsel = 0;
    logic [63:0] sb [128];
    bit          sb_valid [128];

    always #2.5 clk = ~clk;

    icache_diag_port u_dut (
        .clk           (clk),
        .rst           (rst),
        .reg_sel       (reg_sel),
        .reg_rd        (reg_rd),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .tag_plain_acc (tag_plain_acc),
        .tag_incr_acc  (tag_incr_acc)
    );

    function automatic logic [63:0] exp_index();
        logic [63:0] w;
        w = '0;
        w[6:0]   = 7'(m_cnt & 127);
        w[10:7]  = 4'((m_cnt >> 7) & 15);
        w[17:16] = 2'(m_dsel);
        return w;
    endfunction

    function automatic int arr_addr();
        return ((((m_cnt >> 7) & 3) << 5) | ((m_cnt & 7) << 2) | m_dsel);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input bit sel, input bit rd, input bit wr, input logic [63:0] wd,
                       input bit tp, input bit ti, output logic [63:0] rv);
        int a;
        reg_sel = sel; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        tag_plain_acc = tp; tag_incr_acc = ti;
        #1 rv = reg_rdata;
        a = arr_addr();
        if (wr && !sel) begin
            m_dsel = int'(wd[17:16]);
            m_cnt  = int'({wd[10:7], wd[6:0]});
        end else begin
            if (wr && sel) begin
                sb[a] = wd;
                sb_valid[a] = 1'b1;
            end
            if (ti) m_cnt = (m_cnt + 1) & 2047;
            if (tp || ti) m_dsel = 0;
            else if (sel && (rd || wr)) m_dsel = (m_dsel + 1) & 3;
        end
        @(posedge clk);
        @(negedge clk);
        reg_sel = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        tag_plain_acc = 1'b0; tag_incr_acc = 1'b0;
    endtask

    task automatic idx_check(input string req);
        logic [63:0] rv;
        logic [63:0] e;
        e = exp_index();
        bus(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, rv);
        chk(req, rv, e);
    endtask

    task automatic data_rd_check(input string req);
        logic [63:0] rv;
        logic [63:0] e;
        e = sb[arr_addr()];
        bus(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, rv);
        chk(req, rv, e);
    endtask

    task automatic idx_write(input int way, input int line, input int dsel);
        logic [63:0] rv;
        logic [63:0] w;
        w = '0;
        w[6:0] = 7'(line); w[10:7] = 4'(way); w[17:16] = 2'(dsel);
        bus(1'b0, 1'b0, 1'b1, w, 1'b0, 1'b0, rv);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [63:0] rv;
        logic [63:0] d;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        idx_check("R1 reset index");

        // R2: reserved bits stay zero after writing all ones
        bus(1'b0, 1'b0, 1'b1, '1, 1'b0, 1'b0, rv);
        chk("R2 all-ones readback", exp_index(), 64'h0000_0000_0003_07FF);
        idx_check("R2 all-ones index read");

        // R3: index write beats simultaneous tag strobes
        d = '0; d[6:0] = 7'd5; d[10:7] = 4'd9; d[17:16] = 2'd2;
        bus(1'b0, 1'b0, 1'b1, d, 1'b1, 1'b1, rv);
        chk("R3 load priority", exp_index(), 64'h0000_0000_0002_0485);
        idx_check("R3 load over tag strobes");

        // R6: counter wrap from all ones
        idx_write(15, 127, 2);
        idx_check("R3 field load");
        bus(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1, rv);
        idx_check("R6 counter wrap to zero and R5 clear");

        // R7: plain tag holds counter, clears dsel
        idx_write(6, 77, 3);
        bus(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, rv);
        idx_check("R7 plain tag holds way/line, R5 clears dsel");

        // R4, R6, R8: sweep write with auto-increment across a line->way carry
        idx_write(1, 120, 0);
        n = 0;
        for (int ln = 0; ln < 40; ln++) begin
            for (int w = 0; w < 5; w++) begin
                d = 64'hC0DE_0000_0000_0000 ^ (64'(n) * 64'h9E37_79B9_7F4A_7C15);
                n++;
                bus(1'b1, 1'b0, 1'b1, d, 1'b0, 1'b0, rv);
                idx_check("R4 dsel step after data write");
            end
            bus(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1, rv);
            idx_check("R6 auto-increment advance");
        end
        chk("R6 carry into way", exp_index(), 64'h0000_0000_0000_0120);

        // R8: read back all words, including aliased overwrites
        idx_write(1, 120, 0);
        for (int ln = 0; ln < 40; ln++) begin
            for (int w = 0; w < 4; w++) begin
                data_rd_check("R8 data readback");
            end
            idx_check("R4 dsel wrapped after four reads");
            bus(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1, rv);
        end

        // R5: tag strobe in same cycle as data read clears dsel, read still returns word
        idx_write(2, 3, 1);
        d = sb[arr_addr()];
        bus(1'b1, 1'b1, 1'b0, '0, 1'b1, 1'b0, rv);
        chk("R8 read during tag strobe", rv, d);
        idx_check("R5 tag clear overrides data increment");

        // R5 + R8: write during auto-increment tag strobe
        idx_write(3, 6, 2);
        bus(1'b1, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b1, rv);
        idx_check("R5 clear with R6 advance during data write");
        idx_write(3, 6, 2);
        data_rd_check("R8 word written during tag strobe");

        summary();
    end

endmodule